// File: doc/BRIEF.md
# Interrupt Controller Command Word Decoder

This block is the software-facing front end of an eight-input interrupt controller. A host writes single bytes through a two-address synchronous bus. The block turns those bytes into a multi-step initialization sequence and into run-time operation commands. It holds the resulting configuration: trigger mode, single or cascade mode, vector base, cascade map, automatic end-of-interrupt and the mask register. These values go out as plain outputs to the interrupt core, which does the arbitration.

The core reports its pending-request and in-service vectors back to this block. The host can read either of them at address 0, and the mask at address 1. End-of-interrupt commands reach the core as a one-cycle strobe that carries a line number. For the nonspecific form, the block picks the highest set in-service bit itself. Rotation, special-mask and buffering commands are accepted and change nothing.

How many initialization bytes the host must send depends on the first one. What a byte written to address 1 means depends on how far the sequence has got. A static role pin marks the controller as master or slave, and that decides how the third initialization byte is stored.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, edge_mode, cascade_mode, auto_eoi, vector_base, cascade_map, irq_mask and eoi_valid are all zero. A read of address 0 returns req_in.
- R2: A write to address 0 with bit 4 set starts initialization. It clears irq_mask, sets edge_mode to bit 3 and sets cascade_mode to the inverse of bit 1. It records bit 0 as "a fourth byte will follow". The next address-1 write is then taken as the vector base.
- R3: The vector-base byte sets vector_base to the written byte with bits 2:0 forced to zero. In cascade mode the next address-1 byte is the cascade byte. In single mode, cascade_map is cleared and the sequence ends.
- R4: The cascade byte is stored whole in cascade_map when is_master is 1. When is_master is 0, only bits 2:0 are kept, and bits 7:3 read as zero.
- R5: If bit 0 of the starting byte was 1, the byte after the cascade byte is the mode byte: bit 1 of it sets auto_eoi, and the sequence ends. If bit 0 was 0, the start clears auto_eoi, and the sequence ends after the cascade byte.
- R6: An address-1 write outside the initialization sequence loads irq_mask. An address-1 write inside the sequence leaves irq_mask unchanged.
- R7: Address-0 byte with bits 4:3 = 00 and bits 7:5 = 001 (nonspecific EOI). It raises eoi_valid for one cycle, with eoi_line equal to the highest set bit of isr_in. If isr_in is zero, no strobe is issued.
- R8: Address-0 byte with bits 4:3 = 00 and bits 7:5 = 011 (specific EOI). It raises eoi_valid for one cycle, with eoi_line equal to bits 2:0.
- R9: Address-0 bytes with bits 4:3 = 00 and any other value in bits 7:5 change no output and issue no strobe. So do bits 7:6 of a bits-4:3 = 01 byte. Address-0 command bytes leave the initialization step unchanged.
- R10: Address-0 byte with bits 4:3 = 01 and bit 1 set. Bit 0 then selects what address 0 returns: 1 gives req_in, 0 gives isr_in. With bit 1 clear, the selection is kept.
- R11: A read strobe returns data on rd_data in the following cycle. Address 1 returns irq_mask as it was before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Static role: 1 master, 0 slave |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Register address |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid the cycle after bus_rd |
| req_in | input | 8 | Pending-request vector from the core |
| isr_in | input | 8 | In-service vector from the core |
| edge_mode | output | 1 | 1 edge-triggered, 0 level |
| cascade_mode | output | 1 | 1 cascade, 0 single |
| auto_eoi | output | 1 | Automatic end-of-interrupt enable |
| vector_base | output | 8 | Vector base, bits 2:0 zero |
| cascade_map | output | 8 | Slave-input map (master) or own ID (slave) |
| irq_mask | output | 8 | Per-line mask |
| eoi_valid | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | 3 | Line the strobe refers to |

## Verification
A wrong initialization step shows one write later. The next address-1 byte lands in the wrong register, so irq_mask, vector_base, cascade_map or auto_eoi differs at the ports in the cycle after that write. A wrong command decode shows as an eoi_valid strobe that is missing, extra or carries the wrong line, in the cycle after the address-0 write. A wrong read-select flag shows on the next address-0 read. Random byte streams keep the sequencer moving through every step while mask writes, EOI codes and read-select bytes are interleaved with it.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BASE = 2'd1,
        STEP_MAP  = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    typedef enum logic [1:0] {
        KIND_INIT = 2'd0,
        KIND_EOI  = 2'd1,
        KIND_SEL  = 2'd2
    } cmd_kind_e;

    localparam logic [2:0] EOI_CODE_ANY  = 3'b001;
    localparam logic [2:0] EOI_CODE_LINE = 3'b011;

endpackage

// File: rtl/pic_cmd_classify.sv
module pic_cmd_classify
    import pic_cmd_pkg::*;
(
    input  logic [4:0] hi_bits,
    output cmd_kind_e  kind,
    output logic       eoi_any,
    output logic       eoi_line_sel
);
    always_comb begin
        if (hi_bits[1]) begin
            kind = KIND_INIT;
        end else if (hi_bits[0]) begin
            kind = KIND_SEL;
        end else begin
            kind = KIND_EOI;
        end
        eoi_any      = (hi_bits[4:2] == EOI_CODE_ANY);
        eoi_line_sel = (hi_bits[4:2] == EOI_CODE_LINE);
    end
endmodule

// File: rtl/pic_msb_finder.sv
module pic_msb_finder #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [WIDTH:0] above;

    assign above[WIDTH] = 1'b0;

    for (genvar g = WIDTH - 1; g >= 0; g--) begin : g_chain
        assign above[g] = above[g+1] | vec[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i] && !above[i+1]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign found = above[0];
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
    parameter int DATA_W = 8
) (
    input  logic              addr,
    input  logic              show_req,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] isr_vec,
    input  logic [DATA_W-1:0] mask_vec,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        if (addr) begin
            data = mask_vec;
        end else if (show_req) begin
            data = req_vec;
        end else begin
            data = isr_vec;
        end
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] req_in,
    input  logic [DATA_W-1:0] isr_in,
    output logic              edge_mode,
    output logic              cascade_mode,
    output logic              auto_eoi,
    output logic [DATA_W-1:0] vector_base,
    output logic [DATA_W-1:0] cascade_map,
    output logic [DATA_W-1:0] irq_mask,
    output logic              eoi_valid,
    output logic [LINE_W-1:0] eoi_line
);
    typedef struct packed {
        init_step_e        step;
        logic              edge_trig;
        logic              cascade;
        logic              want_mode;
        logic              auto_eoi;
        logic              show_req;
        logic [DATA_W-1:0] vbase;
        logic [DATA_W-1:0] cmap;
        logic [DATA_W-1:0] mask;
        logic              eoi_v;
        logic [LINE_W-1:0] eoi_ln;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        step:      STEP_IDLE,
        edge_trig: 1'b0,
        cascade:   1'b0,
        want_mode: 1'b0,
        auto_eoi:  1'b0,
        show_req:  1'b1,
        vbase:     '0,
        cmap:      '0,
        mask:      '0,
        eoi_v:     1'b0,
        eoi_ln:    '0,
        rdata:     '0
    };

    regs_t q, d;

    cmd_kind_e         kind;
    logic              eoi_any;
    logic              eoi_line_sel;
    logic              isr_found;
    logic [LINE_W-1:0] isr_top;
    logic [DATA_W-1:0] rd_sel;
    logic              seq_idle;

    pic_cmd_classify u_classify (
        .hi_bits      (bus_wdata[7:3]),
        .kind         (kind),
        .eoi_any      (eoi_any),
        .eoi_line_sel (eoi_line_sel)
    );

    pic_msb_finder #(.WIDTH(DATA_W)) u_isr_top (
        .vec   (isr_in),
        .found (isr_found),
        .idx   (isr_top)
    );

    pic_rd_mux #(.DATA_W(DATA_W)) u_rd_mux (
        .addr     (bus_addr),
        .show_req (q.show_req),
        .req_vec  (req_in),
        .isr_vec  (isr_in),
        .mask_vec (q.mask),
        .data     (rd_sel)
    );

    always_comb begin
        d       = q;
        d.eoi_v = 1'b0;

        if (bus_rd) begin
            d.rdata = rd_sel;
        end

        if (bus_wr && !bus_addr) begin
            unique case (kind)
                KIND_INIT: begin
                    d.mask      = '0;
                    d.edge_trig = bus_wdata[3];
                    d.cascade   = ~bus_wdata[1];
                    d.want_mode = bus_wdata[0];
                    if (!bus_wdata[0]) begin
                        d.auto_eoi = 1'b0;
                    end
                    d.step = STEP_BASE;
                end
                KIND_EOI: begin
                    if (eoi_any && isr_found) begin
                        d.eoi_v  = 1'b1;
                        d.eoi_ln = isr_top;
                    end else if (eoi_line_sel) begin
                        d.eoi_v  = 1'b1;
                        d.eoi_ln = bus_wdata[LINE_W-1:0];
                    end
                end
                KIND_SEL: begin
                    if (bus_wdata[1]) begin
                        d.show_req = bus_wdata[0];
                    end
                end
                default: begin
                end
            endcase
        end

        if (bus_wr && bus_addr) begin
            unique case (q.step)
                STEP_IDLE: begin
                    d.mask = bus_wdata;
                end
                STEP_BASE: begin
                    d.vbase = {bus_wdata[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
                    if (q.cascade) begin
                        d.step = STEP_MAP;
                    end else begin
                        d.cmap = '0;
                        d.step = STEP_IDLE;
                    end
                end
                STEP_MAP: begin
                    if (is_master) begin
                        d.cmap = bus_wdata;
                    end else begin
                        d.cmap = DATA_W'(bus_wdata[LINE_W-1:0]);
                    end
                    d.step = q.want_mode ? STEP_MODE : STEP_IDLE;
                end
                STEP_MODE: begin
                    d.auto_eoi = bus_wdata[1];
                    d.step     = STEP_IDLE;
                end
                default: begin
                    d.step = STEP_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign seq_idle     = (q.step == STEP_IDLE);
    assign rd_data      = q.rdata;
    assign edge_mode    = q.edge_trig;
    assign cascade_mode = q.cascade;
    assign auto_eoi     = q.auto_eoi;
    assign vector_base  = q.vbase;
    assign cascade_map  = q.cmap;
    assign irq_mask     = q.mask;
    assign eoi_valid    = q.eoi_v;
    assign eoi_line     = q.eoi_ln;
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
    parameter int DATA_W = 8,
    localparam int LINE_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] isr_in,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] irq_mask,
    input logic              edge_mode,
    input logic              eoi_valid,
    input logic [LINE_W-1:0] eoi_line,
    input logic              seq_idle
);
    assert_init_clears_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4])
        |=> (irq_mask == '0 && edge_mode == $past(bus_wdata[3])));

    assert_idle_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && seq_idle) |=> (irq_mask == $past(bus_wdata)));

    assert_empty_nonspecific_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'b001
         && isr_in == '0) |=> !eoi_valid);

    assert_specific_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == 3'b011)
        |=> (eoi_valid && eoi_line == $past(bus_wdata[LINE_W-1:0])));

    assert_strobe_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_wr && !bus_addr && bus_wdata[4:3] == 2'b00
                            && (bus_wdata[7:5] == 3'b001 || bus_wdata[7:5] == 3'b011)));

    assert_mask_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr) |=> (rd_data == $past(irq_mask)));
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .isr_in    (isr_in),
    .rd_data   (rd_data),
    .irq_mask  (irq_mask),
    .edge_mode (edge_mode),
    .eoi_valid (eoi_valid),
    .eoi_line  (eoi_line),
    .seq_idle  (seq_idle)
);

// File: tb/sim_pic_cmd_decoder.sv
module sim_pic_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic [7:0] req_in = 8'h00;
    logic [7:0] isr_in = 8'h00;
    logic       edge_mode, cascade_mode, auto_eoi, eoi_valid;
    logic [7:0] vector_base, cascade_map, irq_mask;
    logic [2:0] eoi_line;

    int checks = 0;
    int errors = 0;

    // expected-state model, built from the requirements
    int         m_step;
    logic       m_edge, m_casc, m_want, m_aeoi, m_showreq;
    logic [7:0] m_vbase, m_cmap, m_mask;

    always #4 clk = ~clk;

    pic_cmd_decoder u0 (
        .clk (clk), .rst_n (rst_n), .is_master (is_master),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .rd_data (rd_data),
        .req_in (req_in), .isr_in (isr_in),
        .edge_mode (edge_mode), .cascade_mode (cascade_mode), .auto_eoi (auto_eoi),
        .vector_base (vector_base), .cascade_map (cascade_map), .irq_mask (irq_mask),
        .eoi_valid (eoi_valid), .eoi_line (eoi_line)
    );

    function automatic int top_bit(logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_step = 0; m_edge = 0; m_casc = 0; m_want = 0; m_aeoi = 0;
        m_showreq = 1; m_vbase = 0; m_cmap = 0; m_mask = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_cfg(input string tag);
        check({edge_mode, cascade_mode, auto_eoi, vector_base, cascade_map, irq_mask}
              === {m_edge, m_casc, m_aeoi, m_vbase, m_cmap, m_mask}, tag, "config",
              {5'b0, edge_mode, cascade_mode, auto_eoi, vector_base, cascade_map, irq_mask},
              {5'b0, m_edge, m_casc, m_aeoi, m_vbase, m_cmap, m_mask});
    endtask

    // one write: model predicts, bus drives, ports compared one cycle later
    task automatic do_write(input logic a, input logic [7:0] v);
        string tag;
        bit    exp_v = 0;
        int    exp_l = 0;
        if (!a) begin
            if (v[4]) begin
                tag = "R2";
                m_mask = 0; m_edge = v[3]; m_casc = ~v[1]; m_want = v[0];
                if (!v[0]) m_aeoi = 0;
                m_step = 1;
            end else if (v[3]) begin
                tag = "R10";
                if (v[1]) m_showreq = v[0];
            end else if (v[7:5] == 3'b001) begin
                tag = "R7";
                if (isr_in != 0) begin exp_v = 1; exp_l = top_bit(isr_in); end
            end else if (v[7:5] == 3'b011) begin
                tag = "R8";
                exp_v = 1; exp_l = int'(v[2:0]);
            end else begin
                tag = "R9";
            end
        end else begin
            case (m_step)
                0: begin tag = "R6"; m_mask = v; end
                1: begin
                    tag = "R3";
                    m_vbase = {v[7:3], 3'b000};
                    if (m_casc) m_step = 2; else begin m_cmap = 0; m_step = 0; end
                end
                2: begin
                    tag = "R4";
                    m_cmap = is_master ? v : {5'b0, v[2:0]};
                    m_step = m_want ? 3 : 0;
                end
                default: begin tag = "R5"; m_aeoi = v[1]; m_step = 0; end
            endcase
        end
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        check_cfg(tag);
        check(eoi_valid === exp_v, tag, "eoi_valid", 32'(eoi_valid), 32'(exp_v));
        if (exp_v)
            check(eoi_line === 3'(exp_l), tag, "eoi_line", 32'(eoi_line), 32'(exp_l));
    endtask

    task automatic do_read(input logic a, input string tag);
        logic [7:0] exp;
        exp = a ? m_mask : (m_showreq ? req_in : isr_in);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check(rd_data === exp, tag, a ? "read mask" : "read addr0",
              32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17_0C3E));
        model_reset();
        do_reset();

        // R1 reset state
        req_in = 8'h96; isr_in = 8'h41;
        check_cfg("R1");
        check(eoi_valid === 1'b0, "R1", "eoi_valid", 32'(eoi_valid), 0);
        do_read(1'b0, "R1");
        do_read(1'b1, "R11");

        // full master sequence with mode byte
        do_write(0, 8'h19);          // R2 edge, cascade, mode byte follows
        do_write(1, 8'h27);          // R3 base 0x20
        do_write(1, 8'hA5);          // R4 master keeps whole byte
        do_write(1, 8'h03);          // R5 auto_eoi set
        do_write(1, 8'h5A);          // R6 mask load
        do_read(1'b1, "R11");

        // no mode byte: auto_eoi cleared, sequence ends after cascade byte
        do_write(0, 8'h10);          // R5 level, cascade, no mode byte
        check(auto_eoi === 1'b0, "R5", "auto_eoi cleared", 32'(auto_eoi), 0);
        do_write(1, 8'h40);
        do_write(1, 8'h04);
        do_write(1, 8'h33);          // R6 idle again: mask
        check(auto_eoi === 1'b0, "R5", "mode byte skipped", 32'(auto_eoi), 0);

        // single mode: cascade map cleared, ends after base
        do_write(0, 8'h1A);          // R3
        do_write(1, 8'h6F);
        check(cascade_map === 8'h00, "R3", "map cleared", 32'(cascade_map), 0);
        do_write(1, 8'h0F);          // R6

        // command bytes inside the sequence keep the step
        do_write(0, 8'h19);
        do_write(0, 8'h0A);          // R9/R10 read-select, step unchanged
        do_write(0, 8'h60);          // specific EOI line 0 inside sequence
        do_write(1, 8'hFF);          // R6 base, not mask
        check(irq_mask === 8'h00, "R6", "mask untouched in sequence", 32'(irq_mask), 0);
        do_write(1, 8'h81);
        do_write(1, 8'h00);

        // EOI forms
        isr_in = 8'h28;
        do_write(0, 8'h20);          // R7 line 5
        isr_in = 8'h00;
        do_write(0, 8'h20);          // R7 no strobe
        do_write(0, 8'h64);          // R8 line 4
        do_write(0, 8'h67);          // R8 line 7
        for (int c = 0; c < 8; c++) begin
            if (c != 1 && c != 3) do_write(0, {3'(c), 5'b00101});   // R9
        end
        do_write(0, 8'hC8);          // R9 special-mask bits ignored
        do_write(0, 8'h08);          // R10 bit1 clear keeps selection
        isr_in = 8'h5C; req_in = 8'hA3;
        do_read(1'b0, "R10");
        do_write(0, 8'h0B);          // R10 select request
        do_read(1'b0, "R10");
        do_write(0, 8'h0A);          // R10 select in-service
        do_read(1'b0, "R10");

        // slave role
        is_master = 1'b0;
        do_reset();
        check_cfg("R1");
        do_write(0, 8'h11);
        do_write(1, 8'hC3);
        do_write(1, 8'hFD);          // R4 slave keeps bits 2:0 -> 0x05
        check(cascade_map === 8'h05, "R4", "slave id", 32'(cascade_map), 32'h05);
        do_write(1, 8'h02);

        // random mix
        for (int n = 0; n < 1500; n++) begin
            logic [7:0] v;
            int r;
            if (n == 750) begin
                is_master = 1'b1;
                do_reset();
            end
            isr_in = 8'($urandom);
            req_in = 8'($urandom);
            r = int'($urandom_range(0, 9));
            v = 8'($urandom);
            if (r < 4) begin
                do_write(1, v);
            end else if (r < 5) begin
                do_write(0, v | 8'h10);
            end else if (r < 8) begin
                do_write(0, v & 8'hEF);
            end else begin
                do_read(1'($urandom), "R11");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule